// File: doc/BRIEF.md
# Rectangle Pixel Blitter with Colour-Key Skip

This block moves rectangular pixel regions from a set of source bitmaps into one destination bitmap in a shared memory. Software fills a small bank of region descriptors and a table of source base addresses, sets the global pixel depth, row pitch, destination base and key colour, and then pulses `start`. The block walks the valid descriptors one after another and handles a single pixel per step. The step reads the source word and pulls the pixel out of it. A pixel that equals the key colour is skipped. Any other pixel is merged into its destination word by a read-modify-write.

Memory holds pixels packed into 128-bit words. Pixel depth is 8, 16 or 32 bits, so a pixel never crosses a word boundary. Each descriptor carries an operation. The copy operation overwrites the destination pixel. The average operation stores the per-byte mean of the source pixel and the existing destination pixel. When a rectangle is complete its descriptor is retired. After every descriptor has been visited the block drops `busy` and raises `done` for one cycle.

Top module: `rect_blitter`

## Requirements
- R1: `busy` is low after reset and rises on the cycle after `start` is taken while idle. It stays high until every descriptor has been visited. `done` is a one-cycle pulse in the first cycle that `busy` is low again.
- R2: Descriptors are handled in ascending index order. Inside a rectangle the pixels are visited left to right along a row, and the rows are taken top to bottom.
- R3: A pixel at (x, y) of a bitmap based at word B lies in word B + ((y*pitch + x)*bpp) / 128, at bit offset ((y*pitch + x)*bpp) mod 128. The depth code `bpp_sel` selects bpp: 0 gives 8, 1 gives 16, and 2 or 3 gives 32.
- R4: Op code 0 (copy) writes the source pixel into the destination pixel. The write mask covers exactly the bpp bits of that pixel, and the rest of the written word equals the word that was read.
- R5: A source pixel whose value equals the low bpp bits of `key_color` causes no destination read and no destination write.
- R6: Op code 1 (average) writes floor((s + d) / 2) into each 8-bit lane of the destination pixel. Here s is the source lane and d is the existing destination lane.
- R7: A descriptor's 2-bit-per-entry source index selects which source base register supplies B for its source reads.
- R8: Every pixel access is a request on the memory port. Each request is held, with a stable address and direction, until `mem_ack`. Per pixel the order is source read, then destination read, then destination write.
- R9: A descriptor is retired when its rectangle finishes. A second `start` with no new descriptor writes produces no memory access.
- R10: A descriptor with zero width or zero height is retired without any memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_we | input | 1 | Write a descriptor and mark it valid |
| desc_idx | input | IW | Descriptor slot to write |
| desc_src | input | SW | Source base register index |
| desc_sx | input | CW | Source left x |
| desc_sy | input | CW | Source top y |
| desc_dx | input | CW | Destination left x |
| desc_dy | input | CW | Destination top y |
| desc_w | input | CW | Rectangle width in pixels |
| desc_h | input | CW | Rectangle height in pixels |
| desc_op | input | 1 | 0 copy, 1 average |
| base_we | input | 1 | Write a source base register |
| base_idx | input | SW | Source base register to write |
| base_addr | input | AW | Source bitmap base word address |
| dst_base | input | AW | Destination bitmap base word address |
| pitch | input | CW | Row pitch in pixels, shared by all bitmaps |
| bpp_sel | input | 2 | Depth code (R3) |
| key_color | input | 32 | Transparent key colour |
| start | input | 1 | Begin processing the valid descriptors |
| busy | output | 1 | Processing in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_wmask | output | DW | Per-bit write enable |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request accepted; completes it |

## Verification
`busy` is due one clock after `start` is sampled. A request's read data is consumed at the same edge as its `mem_ack`, and the next request appears on the following cycle. `done` rises one clock after the final step or scan. The bench's memory model acts at the falling edge. Each time it acknowledges an access, it compares the request against the next entry of a queue built by a behavioural reference from shadow memory. It checks `done` and `busy` at every falling edge, and at the end of each run it compares the whole memory image with the shadow.

// File: rtl/rect_blitter.sv
module rect_blitter #(
  parameter int NDESC = 8,
  parameter int NSRC  = 4,
  parameter int CW    = 12,
  parameter int AW    = 24,
  parameter int DW    = 128,
  localparam int IW   = (NDESC > 1) ? $clog2(NDESC) : 1,
  localparam int SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_we,
  input  logic [IW-1:0] desc_idx,
  input  logic [SW-1:0] desc_src,
  input  logic [CW-1:0] desc_sx,
  input  logic [CW-1:0] desc_sy,
  input  logic [CW-1:0] desc_dx,
  input  logic [CW-1:0] desc_dy,
  input  logic [CW-1:0] desc_w,
  input  logic [CW-1:0] desc_h,
  input  logic          desc_op,
  input  logic          base_we,
  input  logic [SW-1:0] base_idx,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] dst_base,
  input  logic [CW-1:0] pitch,
  input  logic [1:0]    bpp_sel,
  input  logic [31:0]   key_color,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] mem_wmask,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  localparam int OW = $clog2(DW);
  localparam int LW = 2 * CW + 6;

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_RSRC, S_RDST, S_WDST, S_STEP} st_t;

  st_t st;
  logic [NDESC-1:0] vld, d_op;
  logic [SW-1:0] d_src [NDESC];
  logic [CW-1:0] d_sx [NDESC], d_sy [NDESC], d_dx [NDESC], d_dy [NDESC];
  logic [CW-1:0] d_w [NDESC], d_h [NDESC];
  logic [AW-1:0] sbase [NSRC];
  logic [IW-1:0] ptr;
  logic [CW-1:0] cx, cy;
  logic [31:0]   spix, apix;
  logic [DW-1:0] dword;

  wire          in_dst = (st == S_RDST) || (st == S_WDST);
  wire          last_ptr = (ptr == IW'(NDESC - 1));
  wire [CW-1:0] px = (in_dst ? d_dx[ptr] : d_sx[ptr]) + cx;
  wire [CW-1:0] py = (in_dst ? d_dy[ptr] : d_sy[ptr]) + cy;
  wire [AW-1:0] base = in_dst ? dst_base : sbase[d_src[ptr]];
  wire [2:0]    shamt = bpp_sel[1] ? 3'd5 : (bpp_sel[0] ? 3'd4 : 3'd3);
  wire [31:0]   pmask = bpp_sel[1] ? 32'hFFFF_FFFF : (bpp_sel[0] ? 32'h0000_FFFF : 32'h0000_00FF);
  wire [LW-1:0] lin = LW'(py) * LW'(pitch) + LW'(px);
  wire [LW-1:0] bitpos = lin << shamt;
  wire [OW-1:0] off = bitpos[OW-1:0];
  wire [31:0]   rpix = 32'(mem_rdata >> off) & pmask;
  wire [31:0]   opix = 32'(dword >> off) & pmask;
  wire [31:0]   npix = d_op[ptr] ? apix : spix;
  wire          is_key = (rpix == (key_color & pmask));

  always_comb
    for (int k = 0; k < 4; k++)
      apix[8*k +: 8] = 8'((9'(spix[8*k +: 8]) + 9'(opix[8*k +: 8])) >> 1);

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_RSRC) || in_dst;
  assign mem_we    = (st == S_WDST);
  assign mem_addr  = base + AW'(bitpos >> OW);
  assign mem_wmask = DW'(pmask) << off;
  assign mem_wdata = (dword & ~mem_wmask) | ((DW'(npix) << off) & mem_wmask);

  always_ff @(posedge clk) begin
    if (desc_we) begin
      d_src[desc_idx] <= desc_src;
      d_sx[desc_idx]  <= desc_sx;
      d_sy[desc_idx]  <= desc_sy;
      d_dx[desc_idx]  <= desc_dx;
      d_dy[desc_idx]  <= desc_dy;
      d_w[desc_idx]   <= desc_w;
      d_h[desc_idx]   <= desc_h;
      d_op[desc_idx]  <= desc_op;
    end
    if (base_we) sbase[base_idx] <= base_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      vld   <= '0;
      ptr   <= '0;
      cx    <= '0;
      cy    <= '0;
      spix  <= '0;
      dword <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (desc_we) vld[desc_idx] <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          ptr <= '0;
          cx  <= '0;
          cy  <= '0;
          st  <= S_SCAN;
        end
        S_SCAN:
          if (vld[ptr] && d_w[ptr] != '0 && d_h[ptr] != '0) st <= S_RSRC;
          else begin
            vld[ptr] <= 1'b0;
            if (last_ptr) begin st <= S_IDLE; done <= 1'b1; end
            else begin ptr <= ptr + 1'b1; st <= S_SCAN; end
          end
        S_RSRC: if (mem_ack) begin
          spix <= rpix;
          st   <= is_key ? S_STEP : S_RDST;
        end
        S_RDST: if (mem_ack) begin
          dword <= mem_rdata;
          st    <= S_WDST;
        end
        S_WDST: if (mem_ack) st <= S_STEP;
        S_STEP:
          if (cx == d_w[ptr] - CW'(1)) begin
            cx <= '0;
            if (cy == d_h[ptr] - CW'(1)) begin
              cy <= '0;
              vld[ptr] <= 1'b0;
              if (last_ptr) begin st <= S_IDLE; done <= 1'b1; end
              else begin ptr <= ptr + 1'b1; st <= S_SCAN; end
            end else begin
              cy <= cy + 1'b1;
              st <= S_RSRC;
            end
          end else begin
            cx <= cx + 1'b1;
            st <= S_RSRC;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_key_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RSRC && mem_ack && is_key) |=> !mem_req);
  p_retired_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !desc_we) |-> (vld == '0));
endmodule

// File: tb/rect_blitter_test.sv
`timescale 1ns/1ps
module rect_blitter_test;
  localparam int ND = 8, NS = 4, CW = 12, AW = 24, DW = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic desc_we = 0, desc_op = 0, base_we = 0, start = 0, mem_ack = 0;
  logic [2:0] desc_idx = '0;
  logic [1:0] desc_src = '0, base_idx = '0, bpp_sel = '0;
  logic [CW-1:0] desc_sx = '0, desc_sy = '0, desc_dx = '0, desc_dy = '0, desc_w = '0, desc_h = '0, pitch = '0;
  logic [AW-1:0] base_addr = '0, dst_base = '0;
  logic [31:0] key_color = '0;
  logic [DW-1:0] mem_rdata = '0;
  logic busy, done, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_wmask;

  rect_blitter #(.NDESC(ND), .NSRC(NS), .CW(CW), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .desc_we(desc_we), .desc_idx(desc_idx), .desc_src(desc_src),
    .desc_sx(desc_sx), .desc_sy(desc_sy), .desc_dx(desc_dx), .desc_dy(desc_dy),
    .desc_w(desc_w), .desc_h(desc_h), .desc_op(desc_op), .base_we(base_we),
    .base_idx(base_idx), .base_addr(base_addr), .dst_base(dst_base), .pitch(pitch),
    .bpp_sel(bpp_sel), .key_color(key_color), .start(start), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wmask(mem_wmask), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  typedef struct { bit we; int addr; logic [DW-1:0] data; logic [DW-1:0] mask; } acc_t;
  acc_t q[$];
  logic [DW-1:0] mem [256];
  logic [DW-1:0] shadow [256];
  int b_src [ND], b_sx [ND], b_sy [ND], b_dx [ND], b_dy [ND], b_w [ND], b_h [ND], b_op [ND];
  bit b_v [ND];
  int sb [NS];
  int dstb, pit, bpp, nacc;
  logic [31:0] key;
  int nchk = 0, nerr = 0;

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] pm();
    return bpp == 8 ? 32'hFF : (bpp == 16 ? 32'hFFFF : 32'hFFFF_FFFF);
  endfunction

  function automatic logic [31:0] lane_avg(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = 8'((int'(a[8*k +: 8]) + int'(b[8*k +: 8])) / 2);
    return r;
  endfunction

  task automatic ref_run();
    for (int i = 0; i < ND; i++) begin
      if (b_v[i] && b_w[i] > 0 && b_h[i] > 0)
        for (int y = 0; y < b_h[i]; y++)
          for (int x = 0; x < b_w[i]; x++) begin
            int sl, dl, sa, so, da, dof;
            logic [31:0] p, o, np;
            logic [DW-1:0] m;
            sl = ((b_sy[i] + y) * pit + b_sx[i] + x) * bpp;
            sa = sb[b_src[i]] + sl / 128; so = sl % 128;
            q.push_back('{0, sa, '0, '0});
            p = 32'(shadow[sa] >> so) & pm();
            if (p != (key & pm())) begin
              dl = ((b_dy[i] + y) * pit + b_dx[i] + x) * bpp;
              da = dstb + dl / 128; dof = dl % 128;
              q.push_back('{0, da, '0, '0});
              o = 32'(shadow[da] >> dof) & pm();
              np = b_op[i] ? lane_avg(p, o) : p;
              m = DW'(pm()) << dof;
              shadow[da] = (shadow[da] & ~m) | (DW'(np) << dof);
              q.push_back('{1, da, shadow[da], m});
            end
          end
      b_v[i] = 0;
    end
  endtask

  // memory model and per-cycle checks
  initial forever begin
    @(negedge clk);
    if (rst_n && done) chk(!busy && q.size() == 0, "R1 done with busy low and all accesses seen", {busy, 31'(q.size())}, 0);
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      acc_t e;
      nacc++;
      if (q.size() == 0) chk(0, "R9 R10 unexpected access", DW'(mem_addr), 0);
      else begin
        e = q.pop_front();
        chk(mem_we == e.we && int'(mem_addr) == e.addr, "R2 R3 R5 R7 R8 access order/address",
            {mem_we, DW'(mem_addr)}, {e.we, DW'(e.addr)});
        if (e.we) begin
          chk(mem_wmask == e.mask, "R4 write mask", mem_wmask, e.mask);
          chk(mem_wdata == e.data, "R4 R6 write data", mem_wdata, e.data);
        end
      end
      if (mem_we) mem[mem_addr[7:0]] = (mem[mem_addr[7:0]] & ~mem_wmask) | (mem_wdata & mem_wmask);
      else mem_rdata = mem[mem_addr[7:0]];
      mem_ack = 1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  task automatic set_desc(input int i, s, sx, sy, dx, dy, w, h, op);
    @(negedge clk);
    desc_we = 1; desc_idx = 3'(i); desc_src = 2'(s); desc_sx = CW'(sx); desc_sy = CW'(sy);
    desc_dx = CW'(dx); desc_dy = CW'(dy); desc_w = CW'(w); desc_h = CW'(h); desc_op = op[0];
    b_src[i] = s; b_sx[i] = sx; b_sy[i] = sy; b_dx[i] = dx; b_dy[i] = dy;
    b_w[i] = w; b_h[i] = h; b_op[i] = op; b_v[i] = 1;
    @(negedge clk);
    desc_we = 0;
  endtask

  task automatic set_base(input int i, a);
    @(negedge clk);
    base_we = 1; base_idx = 2'(i); base_addr = AW'(a); sb[i] = a;
    @(negedge clk);
    base_we = 0;
  endtask

  task automatic setup(input int sel, input int kx, ky);
    int l;
    for (int i = 0; i < 256; i++) begin
      mem[i] = {32'(i * 32'h9E37_79B1), 32'(i * 32'h85EB_CA6B + 7), 32'(i * 32'hC2B2_AE35 + 3), 32'(i * 32'h27D4_EB2F)};
      shadow[i] = mem[i];
    end
    @(negedge clk);
    bpp_sel = 2'(sel); bpp = 8 << sel; pit = 24; pitch = 12'd24; dstb = 120; dst_base = 24'd120;
    l = (ky * pit + kx) * bpp;
    key = 32'(mem[sb[0] + l / 128] >> (l % 128)) & pm();
    key_color = key | 32'hA500_0000 & ~pm();
  endtask

  task automatic run(input string tag);
    int n;
    ref_run();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R1 busy one cycle after start", busy, 1);
    n = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1 idle after done pulse", {busy, done}, 0);
    chk(q.size() == 0, {"R2 all expected accesses made ", tag}, q.size(), 0);
    for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) n++;
    chk(n == 0, {"R4 R6 memory image ", tag}, n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 reset state", {busy, done}, 0);
    chk(mem_req == 0, "R8 no request in reset", mem_req, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && mem_req == 0, "R1 idle after reset", {busy, mem_req}, 0);
    set_base(0, 0); set_base(1, 60); set_base(2, 180); set_base(3, 200);

    // 16 bpp: copy, zero-width skip (R10), average, different sources (R7)
    setup(1, 6, 1);
    set_desc(0, 1, 1, 0, 3, 2, 4, 3, 0);
    set_desc(1, 0, 0, 0, 0, 0, 0, 5, 0);
    set_desc(3, 0, 5, 1, 4, 3, 3, 2, 1);
    set_desc(5, 2, 0, 0, 0, 0, 2, 2, 0);
    set_desc(6, 3, 1, 1, 8, 0, 2, 0, 1);
    run("bpp16");

    // 8 bpp: average then copy
    setup(0, 3, 2);
    set_desc(2, 3, 2, 2, 10, 0, 5, 2, 1);
    set_desc(7, 0, 0, 2, 1, 4, 6, 1, 0);
    run("bpp8");

    // 32 bpp
    setup(2, 1, 1);
    set_desc(0, 2, 0, 0, 2, 1, 3, 3, 0);
    set_desc(4, 1, 1, 2, 0, 3, 2, 2, 1);
    run("bpp32");

    // R9: retired descriptors produce no traffic on restart
    nacc = 0;
    run("restart");
    chk(nacc == 0, "R9 no access after descriptors retired", nacc, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule